// File: doc/BRIEF.md
# AHB-Lite Burst Address Sequencer

This block sits on the master side of an AHB-Lite port and produces the address-phase values for one burst at a time. It drives the beat address, the transfer type and the transfer size. It needs only a start address, a size code, a burst code and a one-cycle start strobe. Data movement stays with the surrounding master. The sequencer advances only when the slave reports ready. It inserts BUSY cycles while the master asks for a pause. An undefined-length incrementing burst runs until a stop request arrives.

Each burst is checked before it is issued. A start is rejected with a one-cycle error pulse when any of these holds: the size is wider than the data bus, the start address is not aligned to the size, or a fixed-length incrementing burst would leave its 1 KB region. The block also gives a one-cycle done pulse when the transfer type returns to IDLE after the final beat.

Top module: `ahb_burst_seq`

## Requirements
- R1: After reset `htrans_o` is IDLE (00) and `done_o` and `err_o` are low. A legal start seen while idle gives, from the next cycle, NONSEQ (10) at `start_addr_i`, with `hsize_o` equal to `size_i` for the whole burst.
- R2: Every beat after the first is SEQ (11). For an incrementing burst its address is the previous beat address plus 2^size bytes.
- R3: Burst codes are SINGLE=000, INCR=001, WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110 and INCR16=111, giving 1, undefined, 4, 4, 8, 8, 16 and 16 beats. `done_o` is high for exactly the first IDLE cycle after the last beat is accepted.
- R4: A wrapping burst keeps its addresses inside an aligned window of 2^size × beats bytes and wraps to the window base. For example, WRAP4 of words from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: While a burst is active and `hready_i` is low, `haddr_o`, `htrans_o` and `hsize_o` hold their values.
- R6: When `busy_req_i` is high as a beat is accepted, and another beat follows, the next cycles show BUSY (01) with the next beat's address until `busy_req_i` falls. The burst then resumes with SEQ at that address. BUSY cycles do not count as beats.
- R7: A start of INCR4, INCR8 or INCR16 whose bytes would cross a 1 KB boundary is not issued. `err_o` pulses for one cycle and `htrans_o` stays IDLE.
- R8: A start whose size exceeds the data bus width, or whose address is not aligned to its size, is rejected in the same way as in R7.
- R9: An undefined-length INCR burst ends when `stop_i` is high as a beat is accepted, or during a BUSY cycle with `hready_i` high. `htrans_o` then returns to IDLE.
- R10: When the next beat of an undefined-length INCR burst lies in a new 1 KB region, that beat is issued as NONSEQ instead of SEQ.
- R11: `start_i` is ignored while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_addr_i | input | AW | First beat address |
| size_i | input | 3 | Transfer size code (bytes = 2^size) |
| burst_i | input | 3 | Burst code |
| busy_req_i | input | 1 | Master pause request |
| stop_i | input | 1 | Ends an undefined-length burst |
| hready_i | input | 1 | Slave ready |
| haddr_o | output | AW | Beat address |
| htrans_o | output | 2 | Transfer type |
| hsize_o | output | 3 | Transfer size |
| done_o | output | 1 | Burst completed pulse |
| err_o | output | 1 | Start rejected pulse |

## Verification
The bench covers every burst code. It goes after wrap starts in the middle of the window, as with halfwords from 0x3C and bytes from 0x07, where a wrong window mask would run past the base or wrap at the wrong size. It places a fixed burst that ends exactly on a 1 KB line next to one that crosses it, so an off-by-one limit would either reject a legal burst or issue an illegal one. Wait states are applied both on the NONSEQ beat and mid-burst, and a pause stretched over two BUSY cycles is checked. A design that advanced during these cycles would skip or repeat addresses, or lose the beat count. The bench also tests an undefined burst crossing 1 KB, which must restart with NONSEQ, and a start strobe during an active burst, which would corrupt the sequence if obeyed.

// File: rtl/ahb_burst_pkg.sv
package ahb_burst_pkg;
  typedef enum logic [1:0] {
    HT_IDLE = 2'b00,
    HT_BUSY = 2'b01,
    HT_NSEQ = 2'b10,
    HT_SEQ  = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001,
    BU_WRAP4  = 3'b010,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101,
    BU_WRAP16 = 3'b110,
    BU_INCR16 = 3'b111
  } hburst_e;

  typedef struct packed {
    logic       wrap;
    logic       undef;
    logic [2:0] len_lg;  // log2 of beat count
  } burst_info_t;
endpackage

// File: rtl/ahb_burst_decode.sv
module ahb_burst_decode
  import ahb_burst_pkg::*;
(
  input  logic [2:0]  burst_i,
  output burst_info_t info_o
);
  always_comb begin
    info_o = '0;
    unique case (hburst_e'(burst_i))
      BU_SINGLE: info_o = '{wrap: 1'b0, undef: 1'b0, len_lg: 3'd0};
      BU_INCR:   info_o = '{wrap: 1'b0, undef: 1'b1, len_lg: 3'd0};
      BU_WRAP4:  info_o = '{wrap: 1'b1, undef: 1'b0, len_lg: 3'd2};
      BU_INCR4:  info_o = '{wrap: 1'b0, undef: 1'b0, len_lg: 3'd2};
      BU_WRAP8:  info_o = '{wrap: 1'b1, undef: 1'b0, len_lg: 3'd3};
      BU_INCR8:  info_o = '{wrap: 1'b0, undef: 1'b0, len_lg: 3'd3};
      BU_WRAP16: info_o = '{wrap: 1'b1, undef: 1'b0, len_lg: 3'd4};
      BU_INCR16: info_o = '{wrap: 1'b0, undef: 1'b0, len_lg: 3'd4};
      default:   info_o = '0;
    endcase
  end
endmodule

// File: rtl/ahb_burst_next.sv
module ahb_burst_next #(
  parameter int AW   = 32,
  parameter int KB_W = 10
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic          wrap_i,
  input  logic [2:0]    len_lg_i,
  output logic [AW-1:0] next_o,
  output logic          cross_o
);
  logic [3:0]    win_lg;
  logic [AW-1:0] step, win_mask, incr;

  always_comb begin
    win_lg   = {1'b0, size_i} + {1'b0, len_lg_i};
    step     = AW'(1) << size_i;
    win_mask = (AW'(1) << win_lg) - AW'(1);
    incr     = addr_i + step;
    next_o   = wrap_i ? ((addr_i & ~win_mask) | (incr & win_mask)) : incr;
    cross_o  = next_o[AW-1:KB_W] != addr_i[AW-1:KB_W];
  end
endmodule

// File: rtl/ahb_burst_check.sv
module ahb_burst_check
  import ahb_burst_pkg::*;
#(
  parameter int AW       = 32,
  parameter int KB_W     = 10,
  parameter int MAX_SIZE = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  burst_info_t   info_i,
  output logic          bad_o
);
  logic [3:0]    span_lg;
  logic [AW-1:0] span, align_mask, offset;
  logic          size_bad, misal, kb_cross;

  always_comb begin
    span_lg    = {1'b0, size_i} + {1'b0, info_i.len_lg};
    span       = AW'(1) << span_lg;
    align_mask = (AW'(1) << size_i) - AW'(1);
    offset     = AW'(addr_i[KB_W-1:0]);
    size_bad   = size_i > 3'(MAX_SIZE);
    misal      = |(addr_i & align_mask);
    // only fixed incrementing bursts can run past the region
    kb_cross   = !info_i.wrap && !info_i.undef &&
                 ((offset + span) > (AW'(1) << KB_W));
    bad_o      = size_bad | misal | kb_cross;
  end
endmodule

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq
  import ahb_burst_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int KB_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [2:0]    size_i,
  input  logic [2:0]    burst_i,
  input  logic          busy_req_i,
  input  logic          stop_i,
  input  logic          hready_i,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic [2:0]    hsize_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int MAX_SIZE = $clog2(DW / 8);
  localparam int CNT_W    = 5;

  logic [AW-1:0] addr_q, addr_nxt;
  htrans_e       htrans_q;
  logic [2:0]    size_q;
  burst_info_t   info_q, info_dec;
  logic [CNT_W-1:0] rem_q;
  logic          done_q, err_q, start_bad, cross_nxt;
  logic          active, last;

  ahb_burst_decode u_dec (
    .burst_i (burst_i),
    .info_o  (info_dec)
  );

  ahb_burst_check #(.AW(AW), .KB_W(KB_W), .MAX_SIZE(MAX_SIZE)) u_chk (
    .addr_i (start_addr_i),
    .size_i (size_i),
    .info_i (info_dec),
    .bad_o  (start_bad)
  );

  ahb_burst_next #(.AW(AW), .KB_W(KB_W)) u_nxt (
    .addr_i   (addr_q),
    .size_i   (size_q),
    .wrap_i   (info_q.wrap),
    .len_lg_i (info_q.len_lg),
    .next_o   (addr_nxt),
    .cross_o  (cross_nxt)
  );

  assign active = htrans_q != HT_IDLE;
  assign last   = info_q.undef ? stop_i : (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      htrans_q <= HT_IDLE;
      size_q   <= '0;
      info_q   <= '0;
      rem_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!active) begin
        if (start_i) begin
          if (start_bad) begin
            err_q <= 1'b1;
          end else begin
            addr_q   <= start_addr_i;
            size_q   <= size_i;
            info_q   <= info_dec;
            rem_q    <= CNT_W'(1) << info_dec.len_lg;
            htrans_q <= HT_NSEQ;
          end
        end
      end else if (hready_i) begin
        if (htrans_q == HT_BUSY) begin
          if (info_q.undef && stop_i) begin
            htrans_q <= HT_IDLE;
            done_q   <= 1'b1;
          end else if (!busy_req_i) begin
            htrans_q <= HT_SEQ;
          end
        end else if (last) begin
          htrans_q <= HT_IDLE;
          done_q   <= 1'b1;
        end else begin
          addr_q <= addr_nxt;
          rem_q  <= rem_q - CNT_W'(1);
          // a new 1 KB region restarts with NONSEQ, never BUSY
          if (cross_nxt)       htrans_q <= HT_NSEQ;
          else if (busy_req_i) htrans_q <= HT_BUSY;
          else                 htrans_q <= HT_SEQ;
        end
      end
    end
  end

  assign haddr_o  = addr_q;
  assign htrans_o = htrans_q;
  assign hsize_o  = size_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R5
  hold_on_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != HT_IDLE && !hready_i) |=>
      ($stable(haddr_o) && $stable(htrans_o) && $stable(hsize_o)));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == HT_SEQ && $past(hready_i) && !info_q.wrap &&
     ($past(htrans_o) == HT_NSEQ || $past(htrans_o) == HT_SEQ)) |->
      haddr_o == $past(haddr_o) + (AW'(1) << hsize_o));

  // R4
  wrap_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == HT_SEQ && info_q.wrap) |->
      (((haddr_o ^ $past(haddr_o)) >> ({1'b0, hsize_o} + {1'b0, info_q.len_lg})) == '0));

  // R10
  kb_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o == HT_SEQ |-> haddr_o[AW-1:KB_W] == $past(haddr_o[AW-1:KB_W]));

  // R6
  busy_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o == HT_BUSY |-> $past(htrans_o) != HT_IDLE);

  // R7
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> htrans_o == HT_IDLE);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (htrans_o == HT_IDLE && $past(htrans_o) != HT_IDLE));
endmodule

// File: tb/ahb_burst_seq_bench.sv
module ahb_burst_seq_bench;
  localparam int AW = 32;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    size_i = '0;
  logic [2:0]    burst_i = '0;
  logic          busy_req_i = 1'b0;
  logic          stop_i = 1'b0;
  logic          hready_i = 1'b1;
  logic [AW-1:0] haddr_o;
  logic [1:0]    htrans_o;
  logic [2:0]    hsize_o;
  logic          done_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ahb_burst_seq u_ahb_burst_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .burst_i(burst_i), .busy_req_i(busy_req_i), .stop_i(stop_i),
    .hready_i(hready_i), .haddr_o(haddr_o), .htrans_o(htrans_o), .hsize_o(hsize_o),
    .done_o(done_o), .err_o(err_o)
  );

  // start addr, size, burst, beats, second addr, last addr
  localparam logic [31:0] V_ADDR [NV] = '{32'h34, 32'h100, 32'h3C, 32'h20, 32'h7,
                                           32'h200, 32'h44, 32'h88, 32'h3F0};
  localparam logic [2:0]  V_SIZE [NV] = '{3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd2, 3'd2, 3'd2, 3'd2};
  localparam logic [2:0]  V_BUR  [NV] = '{3'b010, 3'b011, 3'b100, 3'b101, 3'b110,
                                           3'b111, 3'b000, 3'b110, 3'b011};
  localparam int          V_BEATS[NV] = '{4, 4, 8, 8, 16, 16, 1, 16, 4};
  localparam logic [31:0] V_SEC  [NV] = '{32'h38, 32'h104, 32'h3E, 32'h22, 32'h8,
                                           32'h204, 32'h44, 32'h8C, 32'h3F4};
  localparam logic [31:0] V_LAST [NV] = '{32'h30, 32'h10C, 32'h3A, 32'h2E, 32'h6,
                                           32'h23C, 32'h44, 32'h84, 32'h3FC};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_beat(input string req, input logic [1:0] t, input logic [31:0] a);
    chk(htrans_o == t, req, 32'(htrans_o), 32'(t));
    chk(haddr_o == a, req, haddr_o, a);
  endtask

  task automatic start_burst(input logic [31:0] a, input logic [2:0] s, input logic [2:0] b);
    start_addr_i = a; size_i = s; burst_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_vec(input int i);
    int beats;
    logic [31:0] last_a;
    beats = 0;
    last_a = '0;
    start_burst(V_ADDR[i], V_SIZE[i], V_BUR[i]);
    for (int k = 0; k < 40; k++) begin
      if (htrans_o == 2'b00) break;
      if (beats == 0) begin
        chk_beat("R1", 2'b10, V_ADDR[i]);
        chk(hsize_o == V_SIZE[i], "R1", 32'(hsize_o), 32'(V_SIZE[i]));
      end else begin
        chk(htrans_o == 2'b11, "R2", 32'(htrans_o), 32'h3);
      end
      if (beats == 1) chk(haddr_o == V_SEC[i], "R2 R4", haddr_o, V_SEC[i]);
      last_a = haddr_o;
      beats++;
      @(negedge clk);
    end
    chk(beats == V_BEATS[i], "R3", 32'(beats), 32'(V_BEATS[i]));
    chk(last_a == V_LAST[i], "R4", last_a, V_LAST[i]);
    chk(done_o == 1'b1, "R3", 32'(done_o), 32'h1);
    @(negedge clk);
    chk(done_o == 1'b0, "R3", 32'(done_o), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(htrans_o == 2'b00, "R1", 32'(htrans_o), 32'h0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R1", {30'b0, done_o, err_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R5 wait states on NONSEQ and mid-burst
    start_burst(32'h100, 3'd2, 3'b011);
    hready_i = 1'b0;
    @(negedge clk); chk_beat("R5", 2'b10, 32'h100);
    @(negedge clk); chk_beat("R5", 2'b10, 32'h100);
    hready_i = 1'b1;
    @(negedge clk); chk_beat("R5", 2'b11, 32'h104);
    hready_i = 1'b0;
    @(negedge clk); chk_beat("R5", 2'b11, 32'h104);
    hready_i = 1'b1;
    @(negedge clk); chk_beat("R5", 2'b11, 32'h108);
    @(negedge clk); chk_beat("R5", 2'b11, 32'h10C);
    @(negedge clk); chk_beat("R5", 2'b00, 32'h10C);
    @(negedge clk);

    // R6 two BUSY cycles after first beat
    start_burst(32'h0, 3'd2, 3'b011);
    busy_req_i = 1'b1;
    @(negedge clk); chk_beat("R6", 2'b01, 32'h4);
    @(negedge clk); chk_beat("R6", 2'b01, 32'h4);
    busy_req_i = 1'b0;
    @(negedge clk); chk_beat("R6", 2'b11, 32'h4);
    @(negedge clk); chk_beat("R6", 2'b11, 32'h8);
    @(negedge clk); chk_beat("R6", 2'b11, 32'hC);
    @(negedge clk);
    chk(htrans_o == 2'b00 && done_o, "R6", {30'b0, htrans_o}, 32'h0);
    @(negedge clk);

    // R7 INCR8 of words from 0x3F0 crosses 1 KB
    start_burst(32'h3F0, 3'd2, 3'b101);
    chk(err_o == 1'b1, "R7", 32'(err_o), 32'h1);
    chk(htrans_o == 2'b00, "R7", 32'(htrans_o), 32'h0);
    @(negedge clk);
    chk(err_o == 1'b0 && htrans_o == 2'b00, "R7", {29'b0, err_o, htrans_o}, 32'h0);

    // R8 misaligned wrap, oversize
    start_burst(32'h2, 3'd2, 3'b010);
    chk(err_o == 1'b1 && htrans_o == 2'b00, "R8", {29'b0, err_o, htrans_o}, 32'h4);
    @(negedge clk);
    start_burst(32'h0, 3'd3, 3'b011);
    chk(err_o == 1'b1 && htrans_o == 2'b00, "R8", {29'b0, err_o, htrans_o}, 32'h4);
    @(negedge clk);

    // R9 undefined INCR stopped on third beat
    start_burst(32'h10, 3'd2, 3'b001);
    chk_beat("R9", 2'b10, 32'h10);
    @(negedge clk); chk_beat("R9", 2'b11, 32'h14);
    @(negedge clk); chk_beat("R9", 2'b11, 32'h18);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(htrans_o == 2'b00 && done_o, "R9", {30'b0, htrans_o}, 32'h0);
    @(negedge clk);

    // R10 undefined INCR crossing 1 KB
    start_burst(32'h3F8, 3'd2, 3'b001);
    chk_beat("R10", 2'b10, 32'h3F8);
    @(negedge clk); chk_beat("R10", 2'b11, 32'h3FC);
    @(negedge clk); chk_beat("R10", 2'b10, 32'h400);
    @(negedge clk); chk_beat("R10", 2'b11, 32'h404);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(htrans_o == 2'b00, "R10", 32'(htrans_o), 32'h0);
    @(negedge clk);

    // R11 start ignored mid-burst
    start_burst(32'h0, 3'd2, 3'b011);
    start_addr_i = 32'h500; burst_i = 3'b000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk_beat("R11", 2'b11, 32'h4);
    @(negedge clk); chk_beat("R11", 2'b11, 32'h8);
    @(negedge clk); chk_beat("R11", 2'b11, 32'hC);
    @(negedge clk); chk(htrans_o == 2'b00, "R11", 32'(htrans_o), 32'h0);
    @(negedge clk); chk(htrans_o == 2'b00, "R11", 32'(htrans_o), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule